// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit down-counting timer channel for a larger timer subsystem. A load strobe delivers the initial count together with a 3-bit operating mode, a binary/BCD select and an invalid-mode flag. After that, the channel counts down by one on every clock where the count tick `tick_en` is high and the gate permits it. It drives a registered count value and a registered output pulse or level, `out_q`, whose shape depends on the mode.

There are six modes. Mode 0 signals terminal count with a level. Mode 1 is a one-shot started by the gate. Mode 2 is a periodic rate generator. Mode 3 is a square wave. Mode 4 gives a strobe started by the load, and mode 5 a strobe started by the gate. In some modes the gate restarts the count on a rising edge, and in the others it only enables or pauses counting. An initial count of zero stands for the largest count. Count wrap-around follows the selected number base. The register interface, byte sequencing, latching and interrupt delivery belong to the surrounding logic.

Top module: `interval_counter`

## Requirements
- R1: After reset `count_q` reads 0 and `out_q` is low. The channel does not count and does not react to the gate until the first load.
- R2: A loaded value of 0 acts as 65536 in binary mode and 10000 in BCD mode (`bcd_sel`=1, four 4-bit decimal digits). `count_q` reads 0 and steps to FFFF or 9999 on the first counting step.
- R3: In modes 0, 1, 4 and 5 the count does not stop at zero. It steps from 0 to FFFF (binary) or 9999 (BCD) and keeps counting.
- R4: Mode 0 (`mode_sel`=0): `out_q` goes low on load and rises on the N-th counting step. It stays high until the next load.
- R5: Mode 1: `out_q` is high after load and the count waits. A gate rising edge starts it: `out_q` goes low and rises again on the N-th step. Once started, the gate level is ignored.
- R6: Mode 2: the count reloads N on every N-th step. `out_q` is high from that step until the next counting step, and it is not high right after the start.
- R7: Mode 3: with d steps since the start, `out_q` is high when (d mod N) < (N+1)/2 and low otherwise. The count moves down by two per step.
- R8: Mode 4: `out_q` is high only after exactly N steps since load, until the next counting step. It does not fire again after the count wraps.
- R9: Mode 5: like mode 4, but counting starts at a gate rising edge. The gate level is ignored after that.
- R10: In modes 1, 2, 3 and 5, a gate rising edge restarts the count from N, with the output in its start state.
- R11: In modes 0 and 4, gate low pauses counting. A later gate rise does not restart the count.
- R12: When loaded with `mode_bad`=1 or with `mode_sel` of 6 or 7, `out_q` stays low and `count_q` stays frozen until a valid load.
- R13: A load takes effect in the next cycle in every mode, periodic ones included. It overrides a tick and a gate edge in the same cycle.
- R14: `count_q` and `out_q` change only on a counting step, a load or a gate rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count tick; one counting step per clock where high and the gate permits |
| gate | input | 1 | Gate level; a rising edge is detected against the previous clock |
| load_stb | input | 1 | Loads initial count, mode, base select and invalid flag |
| load_val | input | 16 | Initial count (0 = maximum) |
| mode_sel | input | 3 | Operating mode 0..5 |
| bcd_sel | input | 1 | 1 = decimal counting, 0 = binary |
| mode_bad | input | 1 | Marks the loaded mode as invalid |
| count_q | output | 16 | Current count value |
| out_q | output | 1 | Channel output |

## Verification
The assertions assume that the mode is changed only through a load, and that `mode_sel` values 6 and 7 arrive already folded or flagged. They also assume that a counting step needs `tick_en` even when the gate is high. The stimulus keeps to these rules: every mode change goes through `load_stb`, and every tick and gate edge is driven one time unit after a clock edge. Each driven cycle is paired with an elapsed-step reference model whose expected values go into a scoreboard queue. The count is compared in mode 3 only for even binary counts, where the step-by-two sequence is fixed.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam int CW     = 16;
  localparam int XW     = CW + 1;
  localparam int DIGITS = CW / 4;

  typedef logic [XW-1:0] ext_t;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  bcd;
    logic  bad;
    ext_t  init;
  } cfg_t;

  localparam ext_t EXT_MAX = ext_t'(1) << CW;

  function automatic ext_t bcd_top();
    ext_t r;
    r = '0;
    for (int i = 0; i < DIGITS; i++) r[4*i +: 4] = 4'd9;
    return r;
  endfunction

  function automatic ext_t step_down(ext_t v, logic bcd);
    ext_t r;
    logic borrow;
    r      = v;
    borrow = 1'b1;
    if (v[CW-1:0] == '0) begin
      r = bcd ? bcd_top() : ext_t'({CW{1'b1}});
    end else if (!bcd) begin
      r = v - ext_t'(1);
    end else begin
      for (int i = 0; i < DIGITS; i++) begin
        if (borrow) begin
          if (r[4*i +: 4] == 4'd0) begin
            r[4*i +: 4] = 4'd9;
          end else begin
            r[4*i +: 4] = r[4*i +: 4] - 4'd1;
            borrow      = 1'b0;
          end
        end
      end
    end
    r[CW] = 1'b0;
    return r;
  endfunction

  function automatic ext_t step_up(ext_t v, logic bcd);
    ext_t r;
    logic carry;
    r     = v;
    carry = 1'b1;
    if (!bcd) begin
      r = v + ext_t'(1);
    end else begin
      for (int i = 0; i < DIGITS; i++) begin
        if (carry) begin
          if (r[4*i +: 4] >= 4'd9) begin
            r[4*i +: 4] = 4'd0;
          end else begin
            r[4*i +: 4] = r[4*i +: 4] + 4'd1;
            carry       = 1'b0;
          end
        end
      end
      r[CW] = carry;
    end
    return r;
  endfunction

endpackage

// File: rtl/ivc_gate_edge.sv
module ivc_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);

  logic gate_q, gate_d;

  always_comb begin
    gate_d = gate_i;
    rise_o = gate_i & ~gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

endmodule

// File: rtl/ivc_cfg.sv
module ivc_cfg
  import ivc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_stb,
  input  logic [CW-1:0] load_val,
  input  logic [2:0]    mode_sel,
  input  logic          bcd_sel,
  input  logic          mode_bad,
  output cfg_t          cfg_now,
  output mode_e         mode_r,
  output logic          bad_r
);

  cfg_t cfg_q, cfg_d;
  logic out_of_range;

  always_comb begin
    out_of_range = (mode_sel > 3'd5);
    cfg_d        = cfg_q;
    if (load_stb) begin
      cfg_d.mode = out_of_range ? M_TERM : mode_e'(mode_sel);
      cfg_d.bcd  = bcd_sel;
      cfg_d.bad  = mode_bad | out_of_range;
      cfg_d.init = (load_val == '0) ? EXT_MAX : {1'b0, load_val};
    end
    cfg_now = cfg_d;
    mode_r  = cfg_q.mode;
    bad_r   = cfg_q.bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.mode <= M_TERM;
      cfg_q.bcd  <= 1'b0;
      cfg_q.bad  <= 1'b1;
      cfg_q.init <= EXT_MAX;
    end else begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/ivc_core.sv
module ivc_core
  import ivc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic gate_i,
  input  logic gate_rise,
  input  logic load_stb,
  input  cfg_t cfg,
  output ext_t cnt_o,
  output logic out_o
);

  ext_t c_q, c_d;
  logic out_q, out_d;
  logic done_q, done_d;
  logic run_q, run_d;

  logic retrig, lvl_gated, waits_trig, step, at_one;
  ext_t dec1, dec2, hi_rl, lo_rl, start_val;

  // decode and datapath helpers
  always_comb begin
    retrig     = (cfg.mode == M_ONESHOT) || (cfg.mode == M_RATE) ||
                 (cfg.mode == M_SQUARE)  || (cfg.mode == M_HWSTROBE);
    lvl_gated  = (cfg.mode == M_TERM)    || (cfg.mode == M_RATE) ||
                 (cfg.mode == M_SQUARE)  || (cfg.mode == M_SWSTROBE);
    waits_trig = (cfg.mode == M_ONESHOT) || (cfg.mode == M_HWSTROBE);
    step       = tick_en && run_q && (gate_i || !lvl_gated);
    at_one     = (c_q == ext_t'(1));
    dec1       = step_down(c_q, cfg.bcd);
    dec2       = step_down(dec1, cfg.bcd);
    hi_rl      = cfg.init[0] ? step_up(cfg.init, cfg.bcd)   : cfg.init;
    lo_rl      = cfg.init[0] ? step_down(cfg.init, cfg.bcd) : cfg.init;
    start_val  = (cfg.mode == M_SQUARE) ? hi_rl : cfg.init;
  end

  // next state
  always_comb begin
    c_d    = c_q;
    out_d  = out_q;
    done_d = done_q;
    run_d  = run_q;
    if (load_stb) begin
      c_d    = start_val;
      done_d = 1'b0;
      run_d  = !cfg.bad && !waits_trig;
      out_d  = !cfg.bad && ((cfg.mode == M_ONESHOT) || (cfg.mode == M_SQUARE));
    end else if (!cfg.bad && gate_rise && retrig) begin
      c_d    = start_val;
      done_d = 1'b0;
      run_d  = 1'b1;
      out_d  = (cfg.mode == M_SQUARE);
    end else if (!cfg.bad && step) begin
      unique case (cfg.mode)
        M_TERM, M_ONESHOT: begin
          c_d = dec1;
          if (at_one && !done_q) begin
            out_d  = 1'b1;
            done_d = 1'b1;
          end
        end
        M_SWSTROBE, M_HWSTROBE: begin
          c_d   = dec1;
          out_d = at_one && !done_q;
          if (at_one) done_d = 1'b1;
        end
        M_RATE: begin
          if (at_one) begin
            c_d   = cfg.init;
            out_d = 1'b1;
          end else begin
            c_d   = dec1;
            out_d = 1'b0;
          end
        end
        M_SQUARE: begin
          if (c_q <= ext_t'(2)) begin
            if (out_q && (lo_rl != '0)) begin
              c_d   = lo_rl;
              out_d = 1'b0;
            end else begin
              c_d   = hi_rl;
              out_d = 1'b1;
            end
          end else begin
            c_d = dec2;
          end
        end
        default: begin
          c_d = c_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q    <= '0;
      out_q  <= 1'b0;
      done_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      c_q    <= c_d;
      out_q  <= out_d;
      done_q <= done_d;
      run_q  <= run_d;
    end
  end

  assign cnt_o = c_q;
  assign out_o = out_q;

endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import ivc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          load_stb,
  input  logic [CW-1:0] load_val,
  input  logic [2:0]    mode_sel,
  input  logic          bcd_sel,
  input  logic          mode_bad,
  output logic [CW-1:0] count_q,
  output logic          out_q
);

  cfg_t  cfg_now;
  mode_e mode_r;
  logic  bad_r;
  logic  gate_rise;
  ext_t  cnt_ext;
  logic  out_int;

  ivc_gate_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate),
    .rise_o (gate_rise)
  );

  ivc_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_stb (load_stb),
    .load_val (load_val),
    .mode_sel (mode_sel),
    .bcd_sel  (bcd_sel),
    .mode_bad (mode_bad),
    .cfg_now  (cfg_now),
    .mode_r   (mode_r),
    .bad_r    (bad_r)
  );

  ivc_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .gate_i    (gate),
    .gate_rise (gate_rise),
    .load_stb  (load_stb),
    .cfg       (cfg_now),
    .cnt_o     (cnt_ext),
    .out_o     (out_int)
  );

  assign count_q = cnt_ext[CW-1:0];
  assign out_q   = out_int;

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          gate,
  input logic          load_stb,
  input logic [CW-1:0] load_val,
  input logic [2:0]    mode_sel,
  input logic [CW-1:0] count_q,
  input logic          out_q,
  input logic [2:0]    mode_r,
  input logic          bad_r
);

  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_r && !load_stb) |=> (!out_q && $stable(count_q)));  // R12

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_stb && !gate) |=> ($stable(count_q) && $stable(out_q)));  // R14

  AST_TERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_r && mode_r == 3'd0 && out_q && !load_stb) |=> out_q);  // R4

  AST_GATE_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_r && (mode_r == 3'd0 || mode_r == 3'd4) && !gate && !load_stb) |=> $stable(count_q));  // R11

  AST_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_r && mode_r == 3'd4 && out_q && tick_en && gate && !load_stb) |=> !out_q);  // R8

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && mode_sel != 3'd3) |=> (count_q == $past(load_val)));  // R13

endmodule

bind interval_counter ivc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .gate     (gate),
  .load_stb (load_stb),
  .load_val (load_val),
  .mode_sel (mode_sel),
  .count_q  (count_q),
  .out_q    (out_q),
  .mode_r   (mode_r),
  .bad_r    (bad_r)
);

// File: tb/interval_counter_test.sv
module interval_counter_test;
  import ivc_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_en, gate, load_stb, bcd_sel, mode_bad;
  logic [CW-1:0] load_val;
  logic [2:0]    mode_sel;
  logic [CW-1:0] count_q;
  logic          out_q;

  interval_counter uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .load_stb(load_stb), .load_val(load_val), .mode_sel(mode_sel),
    .bcd_sel(bcd_sel), .mode_bad(mode_bad), .count_q(count_q), .out_q(out_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic        eo;
    logic [15:0] ec;
    bit          cc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0;
  int n_err = 0;

  // reference tick model
  int m_mode, m_N, m_d;
  bit m_bcd, m_bad, m_st, m_pg;

  function automatic logic [15:0] int2bcd(int v);
    logic [15:0] r;
    int t;
    t = v;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int bcd2int(logic [15:0] v);
    int r;
    r = 0;
    for (int i = 3; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [15:0] disp(int v);
    return m_bcd ? int2bcd(v) : 16'(v);
  endfunction

  task automatic push_exp(string tag);
    exp_t e;
    int   md, p;
    md    = m_bcd ? 10000 : 65536;
    e.due = cyc + 1;
    e.tag = tag;
    e.cc  = 1'b1;
    p     = m_d % m_N;
    if (m_bad) begin
      e.eo = 1'b0;
      e.ec = disp(m_N % md);
    end else begin
      e.ec = disp((((m_N - m_d) % md) + md) % md);
      case (m_mode)
        0: e.eo = (m_d >= m_N);
        1: e.eo = !m_st || (m_d >= m_N);
        2: begin
          e.eo = (m_d > 0) && (p == 0);
          e.ec = (p == 0) ? disp(m_N % md) : disp(m_N - p);
        end
        3: begin
          e.eo = (p < (m_N + 1) / 2);
          e.cc = (m_N % 2 == 0) && !m_bcd;
          if (e.cc) e.ec = 16'((m_N - 2 * (m_d % (m_N / 2))) % 65536);
        end
        default: e.eo = m_st && (m_d == m_N);
      endcase
    end
    sb.push_back(e);
  endtask

  task automatic drive(bit tk, bit g, bit ld, logic [15:0] v, logic [2:0] md,
                       bit bc, bit bd, string tag);
    bit rise;
    @(posedge clk);
    #1;
    tick_en  = tk;
    gate     = g;
    load_stb = ld;
    load_val = v;
    mode_sel = md;
    bcd_sel  = bc;
    mode_bad = bd;
    rise = g && !m_pg;
    m_pg = g;
    if (ld) begin
      m_bad  = bd || (md > 3'd5);
      m_mode = (md > 3'd5) ? 0 : int'(md);
      m_bcd  = bc;
      m_N    = (v == 16'd0) ? (bc ? 10000 : 65536) : (bc ? bcd2int(v) : int'(v));
      m_d    = 0;
      m_st   = !(m_mode == 1 || m_mode == 5);
    end else if (!m_bad) begin
      if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
        m_d  = 0;
        m_st = 1'b1;
      end else if (tk && m_st && (g || m_mode == 1 || m_mode == 5)) begin
        m_d++;
      end
    end
    push_exp(tag);
  endtask

  task automatic run(int n, bit tk, bit g, string tag);
    for (int i = 0; i < n; i++) drive(tk, g, 1'b0, 16'd0, 3'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic load(logic [15:0] v, logic [2:0] md, bit bc, bit bd, bit g, string tag);
    drive(1'b0, g, 1'b1, v, md, bc, bd, tag);
  endtask

  // monitor: compare design outputs against queued expectations
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (out_q !== e.eo) begin
        n_err++;
        $display("FAIL %s out: actual %0b expected %0b (cycle %0d)", e.tag, out_q, e.eo, cyc);
      end
      if (e.cc) begin
        n_chk++;
        if (count_q !== e.ec) begin
          n_err++;
          $display("FAIL %s count: actual %h expected %h (cycle %0d)", e.tag, count_q, e.ec, cyc);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_err++;
    $display("FAIL R14 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 0; gate = 0; load_stb = 0; load_val = '0;
    mode_sel = '0; bcd_sel = 0; mode_bad = 0;
    m_mode = 0; m_N = 65536; m_d = 0; m_bcd = 0; m_bad = 1; m_st = 0; m_pg = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (count_q !== 16'd0 || out_q !== 1'b0) begin
      n_err++;
      $display("FAIL R1 reset: actual %h/%0b expected 0000/0", count_q, out_q);
    end
    rst_n = 1'b1;

    // R1: idle after reset, ticks and gate edges have no effect
    run(2, 1, 1, "R1"); run(2, 1, 0, "R1"); run(2, 1, 1, "R1");

    // R4 mode 0, then R11 pause and no restart
    load(16'd5, 3'd0, 0, 0, 1, "R4");
    run(8, 1, 1, "R4");
    load(16'd6, 3'd0, 0, 0, 1, "R11");
    run(2, 1, 1, "R11"); run(3, 1, 0, "R11"); run(6, 1, 1, "R11");
    // R14 sparse ticks
    load(16'd3, 3'd0, 0, 0, 1, "R14");
    for (int i = 0; i < 4; i++) begin run(1, 1, 1, "R14"); run(2, 0, 1, "R14"); end

    // R5 one-shot
    load(16'd4, 3'd1, 0, 0, 0, "R5");
    run(3, 1, 0, "R5");
    run(2, 1, 1, "R5"); run(2, 1, 0, "R5"); run(3, 1, 0, "R5");
    // R10 retrigger one-shot mid-count
    run(1, 1, 1, "R10"); run(2, 1, 1, "R10"); run(1, 1, 0, "R10"); run(5, 1, 1, "R10");

    // R6 rate generator, gate pause and restart, reload mid-run
    load(16'd4, 3'd2, 0, 0, 1, "R6");
    run(14, 1, 1, "R6");
    run(3, 1, 0, "R10"); run(6, 1, 1, "R10");
    load(16'd3, 3'd2, 0, 0, 1, "R13");
    run(8, 1, 1, "R13");
    load(16'd1, 3'd2, 0, 0, 1, "R6");
    run(4, 1, 1, "R6");

    // R7 square wave, even and odd counts, count of one
    load(16'd6, 3'd3, 0, 0, 1, "R7");
    run(15, 1, 1, "R7");
    load(16'd5, 3'd3, 0, 0, 1, "R7");
    run(15, 1, 1, "R7");
    run(2, 1, 0, "R10"); run(7, 1, 1, "R10");
    load(16'd1, 3'd3, 0, 0, 1, "R7");
    run(5, 1, 1, "R7");

    // R8 software strobe with gate pause
    load(16'd3, 3'd4, 0, 0, 1, "R8");
    run(2, 1, 1, "R8"); run(2, 1, 0, "R11"); run(5, 1, 1, "R8");

    // R9 hardware strobe, gate level ignored, retrigger
    load(16'd3, 3'd5, 0, 0, 0, "R9");
    run(3, 1, 0, "R9");
    run(1, 1, 1, "R9"); run(1, 1, 0, "R9"); run(4, 1, 0, "R9");
    run(1, 1, 1, "R10"); run(5, 1, 1, "R10");

    // R2/R3 BCD zero count and wrap
    load(16'h0000, 3'd0, 1, 0, 1, "R2");
    run(3, 1, 1, "R2");
    load(16'h0012, 3'd0, 1, 0, 1, "R3");
    run(15, 1, 1, "R3");

    // R12 invalid flag and out-of-range mode
    load(16'd4, 3'd2, 0, 1, 1, "R12");
    run(3, 1, 1, "R12"); run(1, 1, 0, "R12"); run(2, 1, 1, "R12");
    load(16'd4, 3'd6, 0, 0, 1, "R12");
    run(4, 1, 1, "R12");
    load(16'd4, 3'd0, 0, 0, 1, "R12");
    run(5, 1, 1, "R12");

    // R13 load wins over tick and gate edge in the same cycle
    load(16'd7, 3'd2, 0, 0, 0, "R13");
    drive(1, 1, 1, 16'd5, 3'd1, 0, 0, "R13");
    run(7, 1, 1, "R13");

    // R2/R3 binary zero count wraps through full range
    load(16'd0, 3'd0, 0, 0, 1, "R2");
    run(65540, 1, 1, "R3");
    // R8 single strobe is not repeated after wrap
    load(16'd1, 3'd4, 0, 0, 1, "R8");
    run(65540, 1, 1, "R8");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule